// File: doc/BRIEF.md
# Serial ADC Conversion Frame Controller

This block is the host side of a three-wire link to a serial sampling analog-to-digital converter. The link carries a convert strobe out, a serial clock out and a serial data line in. A request on `sample_req` makes the controller raise the convert strobe. Half a serial clock period later it starts a serial clock burst of fixed length. Result bits are shifted in, most significant first, on chosen rising serial clock edges. The finished word is presented in parallel with a one-cycle valid strobe.

The serial clock is derived from the system clock. The system-clock count for each half period is programmable and is clamped to a maximum, so the clock never becomes too slow while a frame runs. Between frames the controller applies two spacing rules. The first is a minimum number of system clocks between successive convert rising edges. The second is a minimum acquisition time, counted from a set rising edge of the previous frame. A request that arrives while the controller is busy is kept and served once both rules allow it. Several such requests merge into one.

A sleep input parks both outputs low. On wake, the controller runs the serial clock for a programmable number of cycles so the converter reference can settle. During that time requests are dropped and `busy` stays high.

Top module: `adc_frame_ctrl`

## Requirements
- R1: During and right after reset, `adc_conv`, `adc_sck`, `busy` and `result_valid` are 0 and `result` is all zeros.
- R2: `adc_sck` is low when `adc_conv` rises. The first rising edge of `adc_sck` comes H system clocks after `adc_conv` rises, where H is the effective half period. Successive rising edges are 2H system clocks apart.
- R3: A conversion frame has exactly FRAME_LEN (default 18) rising edges of `adc_sck`. After the frame `adc_sck` returns low and stays low until the next frame.
- R4: Rising edges are numbered from 1 within a frame. Bits are sampled from `adc_sdo` at rising edges CAP_FIRST+L through CAP_FIRST+L+RES_BITS-1, where L is `capture_late` (0 or 1), CAP_FIRST defaults to 3 and RES_BITS defaults to 14. The first sampled bit becomes the MSB of `result`.
- R5: `result_valid` is high for exactly one system clock after the final result bit is sampled. `result` changes only in a cycle where `result_valid` is high.
- R6: `adc_conv` stays high for max(`conv_width`, 1) system clocks.
- R7: Two successive rising edges of `adc_conv` are at least `period_min` system clocks apart.
- R8: A rising edge of `adc_conv` comes at least `acq_min` system clocks after rising edge ACQ_EDGE (default 16) of the previous frame.
- R9: `busy` is high while a frame runs or a request is held. Any number of requests that arrive while busy produce exactly one further frame, started as soon as R7 and R8 allow.
- R10: The effective half period H is `half_div` clamped to the range 1 to HALF_MAX (default 8). So `half_div` = 0 gives H = 1, and any value above HALF_MAX gives H = HALF_MAX.
- R11: While `sleep_en` is high and no frame is running, `adc_sck` and `adc_conv` stay low, `busy` is high, and requests are dropped.
- R12: When `sleep_en` falls, the controller produces max(`settle_len`, 1) rising edges of `adc_sck` with `busy` high and no `adc_conv` pulse, dropping requests. It then accepts requests again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_req | input | 1 | One-cycle request for a conversion |
| sleep_en | input | 1 | High parks the link; its falling edge starts the settle run |
| capture_late | input | 1 | Shifts the capture window one serial edge later |
| half_div | input | DIV_W | System clocks per serial clock half period, before clamping |
| conv_width | input | CW_W | Minimum convert strobe width in system clocks |
| period_min | input | CNT_W | Minimum system clocks between convert rising edges |
| acq_min | input | CNT_W | Minimum system clocks from the acquisition edge to the next convert |
| settle_len | input | CNT_W | Serial clock cycles to run after wake |
| adc_sdo | input | 1 | Serial data from the converter |
| adc_conv | output | 1 | Convert strobe to the converter |
| adc_sck | output | 1 | Serial clock to the converter |
| busy | output | 1 | Frame running, request held, asleep or settling |
| result | output | RES_BITS | Last captured conversion word |
| result_valid | output | 1 | One-cycle strobe marking a new `result` |

## Verification
The assertions assume that `conv_width`, `period_min`, `acq_min` and `half_div` stay constant while a frame is in flight. The width and spacing checks compare observed intervals against the present values of these inputs. They also assume `sleep_en` is low at the end of reset. The stimulus changes configuration only while `busy` is low, or before issuing the request that begins a test. It drives every input on the falling system clock edge. The converter model changes `adc_sdo` shortly after each serial rising edge, so each bit is stable at the edge that samples it.

// File: rtl/adc_frame_pkg.sv
`timescale 1ns/1ps
package adc_frame_pkg;

    typedef enum logic [1:0] {
        ST_SLEEP  = 2'd0,
        ST_SETTLE = 2'd1,
        ST_IDLE   = 2'd2,
        ST_FRAME  = 2'd3
    } seq_state_e;

    // Keep the serial half period inside [1, hi]
    function automatic int unsigned clamp_half(input int unsigned req, input int unsigned hi);
        if (req == 0) return 1;
        if (req > hi) return hi;
        return req;
    endfunction

endpackage

// File: rtl/adc_sck_gen.sv
`timescale 1ns/1ps
module adc_sck_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] half,
    output logic             sck,
    output logic             rise_now,
    output logic             fall_now
);
    logic [DIV_W-1:0] cnt;
    logic             tick;

    assign tick     = run && (cnt >= half - DIV_W'(1));
    assign rise_now = tick && !sck;
    assign fall_now = tick && sck;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
            sck <= 1'b0;
        end else if (tick) begin
            cnt <= '0;
            sck <= ~sck;
        end else begin
            cnt <= cnt + DIV_W'(1);
        end
    end
endmodule

// File: rtl/adc_gap_timer.sv
`timescale 1ns/1ps
module adc_gap_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear,
    output logic [W-1:0] count
);
    always_ff @(posedge clk) begin
        if (rst)                count <= '1;
        else if (clear)         count <= '0;
        else if (count != '1)   count <= count + W'(1);
    end
endmodule

// File: rtl/adc_shift_in.sv
`timescale 1ns/1ps
module adc_shift_in #(
    parameter int RES_BITS  = 14,
    parameter int CAP_FIRST = 3,
    parameter int EDGE_W    = 6
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                rise_now,
    input  logic [EDGE_W-1:0]   edge_num,
    input  logic                late,
    input  logic                sdo,
    output logic [RES_BITS-1:0] result,
    output logic                valid
);
    logic [EDGE_W-1:0]   first_e, last_e;
    logic [RES_BITS-1:0] shreg;
    logic                in_win, is_last;

    assign first_e = EDGE_W'(CAP_FIRST) + EDGE_W'(late);
    assign last_e  = first_e + EDGE_W'(RES_BITS - 1);
    assign in_win  = rise_now && (edge_num >= first_e) && (edge_num <= last_e);
    assign is_last = rise_now && (edge_num == last_e);

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg  <= '0;
            result <= '0;
            valid  <= 1'b0;
        end else begin
            valid <= is_last;
            if (in_win) shreg <= {shreg[RES_BITS-2:0], sdo};
            if (is_last) result <= {shreg[RES_BITS-2:0], sdo};
        end
    end
endmodule

// File: rtl/adc_frame_ctrl.sv
`timescale 1ns/1ps
module adc_frame_ctrl
    import adc_frame_pkg::*;
#(
    parameter int FRAME_LEN = 18,
    parameter int RES_BITS  = 14,
    parameter int CAP_FIRST = 3,
    parameter int ACQ_EDGE  = 16,
    parameter int DIV_W     = 8,
    parameter int HALF_MAX  = 8,
    parameter int CNT_W     = 16,
    parameter int CW_W      = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                sample_req,
    input  logic                sleep_en,
    input  logic                capture_late,
    input  logic [DIV_W-1:0]    half_div,
    input  logic [CW_W-1:0]     conv_width,
    input  logic [CNT_W-1:0]    period_min,
    input  logic [CNT_W-1:0]    acq_min,
    input  logic [CNT_W-1:0]    settle_len,
    input  logic                adc_sdo,
    output logic                adc_conv,
    output logic                adc_sck,
    output logic                busy,
    output logic [RES_BITS-1:0] result,
    output logic                result_valid
);
    localparam int EDGE_W = $clog2(FRAME_LEN + 2) + 1;

    seq_state_e        state;
    logic              run, rise_now, fall_now;
    logic [DIV_W-1:0]  half_eff;
    logic [EDGE_W-1:0] edge_cnt, edge_num;
    logic              seg_last, pending, acq_armed;
    logic              start, acq_hit, per_ok, acq_ok;
    logic [CNT_W-1:0]  settle_cnt, settle_eff, since_conv, acq_cnt;
    logic [CW_W-1:0]   conv_cnt, conv_w_eff;

    assign half_eff   = DIV_W'(clamp_half(32'(half_div), HALF_MAX));
    assign conv_w_eff = (conv_width == '0) ? CW_W'(1) : conv_width;
    assign settle_eff = (settle_len == '0) ? CNT_W'(1) : settle_len;
    assign edge_num   = edge_cnt + EDGE_W'(1);
    assign run        = (state == ST_FRAME) || (state == ST_SETTLE);

    assign per_ok  = ({1'b0, since_conv} + (CNT_W+1)'(1)) >= {1'b0, period_min};
    assign acq_ok  = acq_armed && (({1'b0, acq_cnt} + (CNT_W+1)'(1)) >= {1'b0, acq_min});
    assign start   = (state == ST_IDLE) && pending && !sleep_en && per_ok && acq_ok;
    assign acq_hit = (state == ST_FRAME) && rise_now && (edge_num == EDGE_W'(ACQ_EDGE));
    assign busy    = (state != ST_IDLE) || pending || adc_conv;

    adc_sck_gen #(.DIV_W(DIV_W)) i_sck (
        .clk(clk), .rst(rst), .run(run), .half(half_eff),
        .sck(adc_sck), .rise_now(rise_now), .fall_now(fall_now)
    );

    adc_gap_timer #(.W(CNT_W)) i_period_tmr (
        .clk(clk), .rst(rst), .clear(start), .count(since_conv)
    );

    adc_gap_timer #(.W(CNT_W)) i_acq_tmr (
        .clk(clk), .rst(rst), .clear(acq_hit), .count(acq_cnt)
    );

    adc_shift_in #(.RES_BITS(RES_BITS), .CAP_FIRST(CAP_FIRST), .EDGE_W(EDGE_W)) i_shift (
        .clk(clk), .rst(rst), .rise_now(rise_now && (state == ST_FRAME)),
        .edge_num(edge_num), .late(capture_late), .sdo(adc_sdo),
        .result(result), .valid(result_valid)
    );

    // Sequencer
    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            edge_cnt   <= '0;
            seg_last   <= 1'b0;
            settle_cnt <= '0;
            pending    <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (sleep_en) begin
                        state   <= ST_SLEEP;
                        pending <= 1'b0;
                    end else if (start) begin
                        state    <= ST_FRAME;
                        edge_cnt <= '0;
                        seg_last <= 1'b0;
                        pending  <= 1'b0;
                    end else if (sample_req) begin
                        pending <= 1'b1;
                    end
                end
                ST_FRAME: begin
                    if (sample_req) pending <= 1'b1;
                    if (rise_now) begin
                        edge_cnt <= edge_num;
                        if (edge_num == EDGE_W'(FRAME_LEN)) seg_last <= 1'b1;
                    end
                    if (fall_now && seg_last) state <= ST_IDLE;
                end
                ST_SLEEP: begin
                    pending <= 1'b0;
                    if (!sleep_en) begin
                        state      <= ST_SETTLE;
                        settle_cnt <= '0;
                        seg_last   <= 1'b0;
                    end
                end
                ST_SETTLE: begin
                    pending <= 1'b0;
                    if (rise_now) begin
                        settle_cnt <= settle_cnt + CNT_W'(1);
                        if (settle_cnt + CNT_W'(1) >= settle_eff) seg_last <= 1'b1;
                    end
                    if (fall_now && seg_last) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Convert strobe width
    always_ff @(posedge clk) begin
        if (rst) begin
            adc_conv <= 1'b0;
            conv_cnt <= '0;
        end else if (start) begin
            adc_conv <= 1'b1;
            conv_cnt <= '0;
        end else if (adc_conv) begin
            if (conv_cnt + CW_W'(1) >= conv_w_eff) adc_conv <= 1'b0;
            else                                   conv_cnt <= conv_cnt + CW_W'(1);
        end
    end

    // Acquisition window bookkeeping for the spacing rule
    always_ff @(posedge clk) begin
        if (rst)          acq_armed <= 1'b1;
        else if (start)   acq_armed <= 1'b0;
        else if (acq_hit) acq_armed <= 1'b1;
    end
endmodule

// File: rtl/adc_frame_ctrl_chk.sv
`timescale 1ns/1ps
module adc_frame_ctrl_chk #(
    parameter int RES_BITS = 14,
    parameter int ACQ_EDGE = 16,
    parameter int DIV_W    = 8,
    parameter int HALF_MAX = 8,
    parameter int CNT_W    = 16,
    parameter int CW_W     = 4
) (
    input logic                clk,
    input logic                rst,
    input logic                sleep_en,
    input logic [CW_W-1:0]     conv_width,
    input logic [CNT_W-1:0]    period_min,
    input logic [CNT_W-1:0]    acq_min,
    input logic                adc_conv,
    input logic                adc_sck,
    input logic [RES_BITS-1:0] result,
    input logic                result_valid
);
    logic             conv_q, sck_q;
    logic [CW_W:0]    conv_hi;
    logic [CNT_W-1:0] conv_gap, acq_gap;
    logic [7:0]       rise_idx;
    logic [DIV_W:0]   sck_hi;
    logic             conv_up, conv_dn, sck_up;

    assign conv_up = adc_conv && !conv_q;
    assign conv_dn = !adc_conv && conv_q;
    assign sck_up  = adc_sck && !sck_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            conv_q   <= 1'b0;
            sck_q    <= 1'b0;
            conv_hi  <= '0;
            conv_gap <= '1;
            acq_gap  <= '1;
            rise_idx <= '1;
            sck_hi   <= '0;
        end else begin
            conv_q  <= adc_conv;
            sck_q   <= adc_sck;
            conv_hi <= adc_conv ? conv_hi + (CW_W+1)'(1) : '0;
            sck_hi  <= adc_sck ? sck_hi + (DIV_W+1)'(1) : '0;
            if (conv_up)                conv_gap <= CNT_W'(1);
            else if (conv_gap != '1)    conv_gap <= conv_gap + CNT_W'(1);
            if (conv_up)                               rise_idx <= '0;
            else if (sck_up && rise_idx != '1)         rise_idx <= rise_idx + 8'(1);
            if (sck_up && (rise_idx + 8'(1) == 8'(ACQ_EDGE))) acq_gap <= CNT_W'(1);
            else if (acq_gap != '1)                           acq_gap <= acq_gap + CNT_W'(1);
        end
    end

    // R2
    conv_lead_chk: assert property (@(posedge clk) disable iff (rst)
        conv_up |-> !adc_sck);

    // R5
    valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        result_valid |=> !result_valid);

    // R5
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !result_valid |-> $stable(result));

    // R6
    conv_width_chk: assert property (@(posedge clk) disable iff (rst)
        conv_dn |-> (conv_hi == ((conv_width == '0) ? (CW_W+1)'(1) : {1'b0, conv_width})));

    // R7
    conv_period_chk: assert property (@(posedge clk) disable iff (rst)
        conv_up |-> (conv_gap >= period_min));

    // R8
    acq_window_chk: assert property (@(posedge clk) disable iff (rst)
        conv_up |-> (acq_gap >= acq_min));

    // R10
    sck_half_max_chk: assert property (@(posedge clk) disable iff (rst)
        sck_hi <= (DIV_W+1)'(HALF_MAX));

    // R11
    sleep_no_conv_chk: assert property (@(posedge clk) disable iff (rst)
        conv_up |-> !$past(sleep_en));
endmodule

bind adc_frame_ctrl adc_frame_ctrl_chk #(
    .RES_BITS(RES_BITS), .ACQ_EDGE(ACQ_EDGE), .DIV_W(DIV_W),
    .HALF_MAX(HALF_MAX), .CNT_W(CNT_W), .CW_W(CW_W)
) i_chk (
    .clk(clk), .rst(rst), .sleep_en(sleep_en), .conv_width(conv_width),
    .period_min(period_min), .acq_min(acq_min), .adc_conv(adc_conv),
    .adc_sck(adc_sck), .result(result), .result_valid(result_valid)
);

// File: tb/test_adc_frame_ctrl.sv
`timescale 1ns/1ps
module test_adc_frame_ctrl;
    localparam int FRAME_LEN = 18;
    localparam int RES_BITS  = 14;
    localparam int CAP_FIRST = 3;
    localparam int ACQ_EDGE  = 16;
    localparam int DIV_W     = 8;
    localparam int HALF_MAX  = 8;
    localparam int CNT_W     = 16;
    localparam int CW_W      = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sample_req = 1'b0, sleep_en = 1'b0, capture_late = 1'b0;
    logic [DIV_W-1:0] half_div = 8'd2;
    logic [CW_W-1:0]  conv_width = 4'd3;
    logic [CNT_W-1:0] period_min = 16'd1, acq_min = 16'd1, settle_len = 16'd5;
    logic adc_sdo = 1'b0;
    logic adc_conv, adc_sck, busy, result_valid;
    logic [RES_BITS-1:0] result;

    always #10 clk = ~clk;

    adc_frame_ctrl #(
        .FRAME_LEN(FRAME_LEN), .RES_BITS(RES_BITS), .CAP_FIRST(CAP_FIRST),
        .ACQ_EDGE(ACQ_EDGE), .DIV_W(DIV_W), .HALF_MAX(HALF_MAX),
        .CNT_W(CNT_W), .CW_W(CW_W)
    ) i_adc_frame_ctrl (
        .clk(clk), .rst(rst), .sample_req(sample_req), .sleep_en(sleep_en),
        .capture_late(capture_late), .half_div(half_div), .conv_width(conv_width),
        .period_min(period_min), .acq_min(acq_min), .settle_len(settle_len),
        .adc_sdo(adc_sdo), .adc_conv(adc_conv), .adc_sck(adc_sck), .busy(busy),
        .result(result), .result_valid(result_valid)
    );

    int checks = 0, errors = 0;
    int cyc = 0;

    // Converter model
    logic [RES_BITS-1:0] code = '0;
    int model_late = 0;
    int m_r = 0;

    function automatic logic bitv(input int e);
        int idx;
        idx = e - (CAP_FIRST + model_late);
        if (idx >= 0 && idx < RES_BITS) return code[RES_BITS-1-idx];
        return 1'b0;
    endfunction

    always @(posedge adc_conv) begin
        m_r = 0;
        adc_sdo = bitv(1);
    end

    always @(posedge adc_sck) begin
        m_r = m_r + 1;
        #1 adc_sdo = bitv(m_r + 1);
    end

    // Monitors, sampled away from the active edge
    always @(posedge clk) cyc <= cyc + 1;

    int conv_rises = 0, last_conv = 0, gap_conv = 0, gap_acq = 0;
    int conv_hi = 0, conv_len = 0;
    int rises = 0, sck_total = 0, first_rise = 0, second_rise = 0, acq_at = 0;
    int vcount = 0, vlen = 0, last_vlen = 0;
    logic m_conv_q = 1'b0, m_sck_q = 1'b0;

    always @(negedge clk) begin
        if (!rst) begin
            if (adc_conv && !m_conv_q) begin
                conv_rises = conv_rises + 1;
                gap_conv   = cyc - last_conv;
                last_conv  = cyc;
                gap_acq    = cyc - acq_at;
                rises      = 0;
            end
            if (adc_conv) conv_hi = m_conv_q ? conv_hi + 1 : 1;
            else if (m_conv_q) conv_len = conv_hi;
            if (adc_sck && !m_sck_q) begin
                rises     = rises + 1;
                sck_total = sck_total + 1;
                if (rises == 1) first_rise = cyc;
                if (rises == 2) second_rise = cyc;
                if (rises == ACQ_EDGE) acq_at = cyc;
            end
            if (result_valid) begin
                if (vlen == 0) vcount = vcount + 1;
                vlen = vlen + 1;
            end else if (vlen > 0) begin
                last_vlen = vlen;
                vlen = 0;
            end
            m_conv_q = adc_conv;
            m_sck_q  = adc_sck;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_req();
        @(negedge clk) sample_req = 1'b1;
        @(negedge clk) sample_req = 1'b0;
    endtask

    task automatic wait_valid();
        int n = 0;
        while (!result_valid && n < 5000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic wait_idle();
        int n = 0;
        while (busy && n < 20000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic t_reset();
        rst = 1'b1;
        idle(4);
        chk("R1 conv in reset", int'(adc_conv), 0);
        chk("R1 sck in reset", int'(adc_sck), 0);
        rst = 1'b0;
        idle(1);
        chk("R1 busy after reset", int'(busy), 0);
        chk("R1 valid after reset", int'(result_valid), 0);
        chk("R1 result after reset", int'(result), 0);
    endtask

    task automatic t_basic();
        half_div = 8'd2; conv_width = 4'd3; capture_late = 1'b0; model_late = 0;
        code = 14'h2A5C;
        pulse_req();
        chk("R9 busy after request", int'(busy), 1);
        wait_valid();
        chk("R4 result basic", int'(result), int'(14'h2A5C));
        chk("R2 conv to first sck", first_rise - last_conv, 2);
        chk("R2 sck period", second_rise - first_rise, 4);
        wait_idle();
        idle(2);
        chk("R3 rising edges per frame", rises, FRAME_LEN);
        chk("R3 sck low after frame", int'(adc_sck), 0);
        chk("R6 conv width", conv_len, 3);
        chk("R5 valid width", last_vlen, 1);
    endtask

    task automatic t_late();
        logic [RES_BITS-1:0] held;
        capture_late = 1'b1; model_late = 1; code = 14'h1C3A; conv_width = 4'd0;
        pulse_req();
        wait_valid();
        chk("R4 late capture", int'(result), int'(14'h1C3A));
        held = result;
        wait_idle();
        idle(20);
        chk("R5 result held", int'(result), int'(held));
        chk("R6 zero width gives one", conv_len, 1);
        capture_late = 1'b0; code = 14'h3E01;
        pulse_req();
        wait_valid();
        chk("R4 window offset mismatch", int'(result), int'(14'h3E01 >> 1));
        wait_idle();
        model_late = 0;
        idle(5);
    endtask

    task automatic t_period();
        int c0, v0;
        period_min = 16'd100; acq_min = 16'd1; conv_width = 4'd2;
        idle(120);
        c0 = conv_rises; v0 = vcount;
        code = 14'h0F0F;
        pulse_req();
        idle(5);
        pulse_req();
        pulse_req();
        pulse_req();
        wait_idle();
        idle(10);
        chk("R9 merged requests give two frames", conv_rises - c0, 2);
        chk("R7 conv spacing", gap_conv, 100);
        chk("R9 two results", vcount - v0, 2);
        chk("R4 result second frame", int'(result), int'(14'h0F0F));
        period_min = 16'd1;
    endtask

    task automatic t_acq();
        acq_min = 16'd20;
        idle(40);
        pulse_req();
        idle(3);
        pulse_req();
        wait_idle();
        idle(5);
        chk("R8 acquisition spacing", gap_acq, 20);
        acq_min = 16'd1;
    endtask

    task automatic t_clamp();
        half_div = 8'd0;
        pulse_req();
        wait_valid();
        chk("R10 zero divider lead", first_rise - last_conv, 1);
        chk("R10 zero divider period", second_rise - first_rise, 2);
        wait_idle();
        half_div = 8'd200;
        code = 14'h2001;
        pulse_req();
        wait_valid();
        chk("R10 clamped lead", first_rise - last_conv, HALF_MAX);
        chk("R10 clamped period", second_rise - first_rise, 2 * HALF_MAX);
        chk("R4 result slow clock", int'(result), int'(14'h2001));
        wait_idle();
        half_div = 8'd2;
        idle(5);
    endtask

    task automatic t_sleep();
        int c0, s0;
        settle_len = 16'd5;
        @(negedge clk) sleep_en = 1'b1;
        idle(3);
        c0 = conv_rises; s0 = sck_total;
        pulse_req();
        idle(30);
        chk("R11 busy asleep", int'(busy), 1);
        chk("R11 no conv asleep", conv_rises - c0, 0);
        chk("R11 no sck asleep", sck_total - s0, 0);
        @(negedge clk) sleep_en = 1'b0;
        idle(4);
        chk("R12 busy settling", int'(busy), 1);
        pulse_req();
        wait_idle();
        idle(20);
        chk("R12 settle sck cycles", sck_total - s0, 5);
        chk("R12 no conv while settling", conv_rises - c0, 0);
        code = 14'h1234;
        pulse_req();
        wait_valid();
        chk("R12 accepts after settle", int'(result), int'(14'h1234));
        wait_idle();
    endtask

    initial begin
        t_reset();
        t_basic();
        t_late();
        t_period();
        t_acq();
        t_clamp();
        t_sleep();
        idle(5);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks = checks + 1;
        errors = errors + 1;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule